// File: doc/BRIEF.md
# Two-Axis Memory Self-Test Address Sequencer

This block produces the address stream for a memory self-test engine. The address space is split into two nested counters: an x counter that drives the row lines and a y counter that drives the column, doubleword and block lines. Each counter's width is set at run time by a 4-bit code. One counter is the fast axis and steps once for every address issued. The other counter steps only when the fast one wraps. Both counters count in the same direction, up or down.

Each counter pair is remapped into a physical RAM address. The two least significant output bits select the doubleword, and only for a data RAM. Above them sit the column bits, whose lowest bit is scrambled with an XOR. The row bits come next, and any leftover y bits form the block field at the top.

Addresses leave on a valid/ready stream. An address is transferred on a clock edge where `addr_valid` and `addr_ready` are both high. While `addr_valid` is high and `addr_ready` is low, the address holds and no counter moves. `addr_ready` may change freely while `addr_valid` is low. The control and status pins are plain levels or pulses.

Top module: `mbist_addr_gen`

## Requirements
- R1: A start is rejected when `x_code` lies outside 2..8 or `y_code` lies outside 2..10. A rejected start sets `cfg_err` and produces no address. An accepted start clears `cfg_err`.
- R2: A start is also rejected, with `cfg_err` set, when `col_bits` is below 2, or when `col_bits` plus the doubleword count exceeds `y_code`. The doubleword count is 2 when `data_ram` is 1 and 0 otherwise.
- R3: The fast counter (y when `fast_y`=1, x otherwise) steps on every issued address. The slow counter steps only on the address where the fast counter wraps.
- R4: When counting up, each counter starts at 0 and wraps from 2^width−1 to 0. When counting down (`count_down`=1), each counter starts at 2^width−1 and wraps from 0 to 2^width−1.
- R5: Let c = `col_bits`. Address bits [2+c−1:2] carry y[c−1:0]. Bits [2+c+xw−1:2+c] carry x. The block field y[yw−1:c+dw] follows directly above the row bits, where dw is the doubleword count.
- R6: Address bit 2 equals y[0] XOR y[1]. The other column bits are copied unchanged.
- R7: With `data_ram`=1, address bits [1:0] carry y[c+1:c]. With `data_ram`=0, address bits [1:0] are 0 and the block field starts at y[c].
- R8: Every address bit at or above position 2+xw+yw−dw is 0.
- R9: A run issues exactly 2^(xw+yw) addresses, in counter order, with none lost or repeated under back-pressure. A stalled address stays stable until it is accepted.
- R10: `done` pulses high for one cycle, in the cycle after the final address is accepted. A start seen while a run is still issuing addresses is ignored.
- R11: After reset, `addr_valid`, `done` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| count_down | input | 1 | 1 = both counters count down |
| fast_y | input | 1 | 1 = y is the fast axis, 0 = x is the fast axis |
| data_ram | input | 1 | Target has doubleword select bits |
| col_bits | input | 4 | Number of column select bits |
| x_code | input | 4 | Row counter width code |
| y_code | input | 4 | Column/block counter width code |
| addr_valid | output | 1 | Address stream valid |
| addr_ready | input | 1 | Address stream ready |
| addr | output | 20 | Physical test address |
| done | output | 1 | One-cycle pulse after the final address is accepted |
| cfg_err | output | 1 | Last start was rejected for a bad configuration |

## Verification
The assertions assume that `addr_ready` is driven to a defined level every cycle. They also assume that the configuration inputs only need to be valid in the cycle that `start` is accepted, since they are captured at that point. The stimulus keeps the total counter width at 8 bits or less in its random runs, so each sequence stays short. One directed run uses the widest practical data-RAM layout. Invalid codes are driven only on a start issued while the block is idle, or as an injected start during a live run to confirm that it is ignored.

// File: rtl/mbist_ag_pkg.sv
package mbist_ag_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic [CODE_W-1:0] xw;
    logic [CODE_W-1:0] yw;
    logic [CODE_W-1:0] cb;
    logic              data;
    logic              down;
    logic              fast_y;
  } ag_cfg_t;
endpackage

// File: rtl/mbist_ag_cfgchk.sv
module mbist_ag_cfgchk
  import mbist_ag_pkg::*;
#(
  parameter int XW_MAX = 8,
  parameter int YW_MAX = 10
) (
  input  logic [CODE_W-1:0] x_code,
  input  logic [CODE_W-1:0] y_code,
  input  logic [CODE_W-1:0] col_code,
  input  logic              data_ram,
  output logic              cfg_ok
);
  localparam int MIN_W = 2;

  always_comb begin
    int xv, yv, cv, dv;
    xv = int'(x_code);
    yv = int'(y_code);
    cv = int'(col_code);
    dv = data_ram ? 2 : 0;
    cfg_ok = (xv >= MIN_W) && (xv <= XW_MAX) &&
             (yv >= MIN_W) && (yv <= YW_MAX) &&
             (cv >= MIN_W) && (cv + dv <= yv);
  end
endmodule

// File: rtl/mbist_ag_axis.sv
module mbist_ag_axis
  import mbist_ag_pkg::*;
#(
  parameter int W_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] width,
  input  logic              down,
  input  logic              init,
  input  logic              step,
  output logic [W_MAX-1:0]  cnt,
  output logic              at_end
);
  logic [W_MAX-1:0] mask;

  always_comb begin
    for (int i = 0; i < W_MAX; i++) mask[i] = (i < int'(width));
    at_end = down ? (cnt == '0) : (cnt == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (init) begin
      cnt <= down ? mask : '0;
    end else if (step) begin
      if (at_end) cnt <= down ? mask : '0;
      else        cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  // R4: counter never leaves its programmed range
  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !init |-> ((cnt & ~mask) == '0));
endmodule

// File: rtl/mbist_ag_map.sv
module mbist_ag_map
  import mbist_ag_pkg::*;
#(
  parameter int XW_MAX = 8,
  parameter int YW_MAX = 10,
  localparam int ADDR_W = 2 + XW_MAX + YW_MAX
) (
  input  logic [XW_MAX-1:0] xv,
  input  logic [YW_MAX-1:0] yv,
  input  logic [CODE_W-1:0] xw,
  input  logic [CODE_W-1:0] yw,
  input  logic [CODE_W-1:0] cb,
  input  logic              data,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    int c, xn, yn, dv;
    c  = int'(cb);
    xn = int'(xw);
    yn = int'(yw);
    dv = data ? 2 : 0;
    addr = '0;
    if (data) begin
      for (int j = 0; j < 2; j++)
        if (c + j < YW_MAX) addr[j] = yv[c + j];
    end
    for (int j = 0; j < YW_MAX; j++)
      if (j < c) addr[2 + j] = (j == 0) ? (yv[0] ^ yv[1]) : yv[j];
    for (int j = 0; j < XW_MAX; j++)
      if (j < xn && 2 + c + j < ADDR_W) addr[2 + c + j] = xv[j];
    for (int j = 0; j < YW_MAX; j++)
      if (j < yn - c - dv && 2 + c + xn + j < ADDR_W && c + dv + j < YW_MAX)
        addr[2 + c + xn + j] = yv[c + dv + j];
  end
endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen
  import mbist_ag_pkg::*;
#(
  parameter int XW_MAX = 8,
  parameter int YW_MAX = 10,
  localparam int ADDR_W = 2 + XW_MAX + YW_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              count_down,
  input  logic              fast_y,
  input  logic              data_ram,
  input  logic [CODE_W-1:0] col_bits,
  input  logic [CODE_W-1:0] x_code,
  input  logic [CODE_W-1:0] y_code,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              cfg_err
);
  ag_cfg_t cfg_in, cfg_q, cfg_use;
  logic cfg_ok, busy, active, go, rej, load, final_pt;
  logic out_valid, out_last, done_q, err_q;
  logic [ADDR_W-1:0] out_addr, map_addr;
  logic [XW_MAX-1:0] xcnt;
  logic [YW_MAX-1:0] ycnt;
  logic x_end, y_end, x_step, y_step;

  always_comb begin
    cfg_in = '{xw: x_code, yw: y_code, cb: col_bits, data: data_ram,
               down: count_down, fast_y: fast_y};
    active   = busy | out_valid;
    go       = start & ~active & cfg_ok;
    rej      = start & ~active & ~cfg_ok;
    cfg_use  = go ? cfg_in : cfg_q;
    load     = busy & (~out_valid | addr_ready);
    final_pt = x_end & y_end;
    x_step   = cfg_q.fast_y ? (load & y_end) : load;
    y_step   = cfg_q.fast_y ? load : (load & x_end);
  end

  mbist_ag_cfgchk #(.XW_MAX(XW_MAX), .YW_MAX(YW_MAX)) u_chk (
    .x_code(x_code), .y_code(y_code), .col_code(col_bits),
    .data_ram(data_ram), .cfg_ok(cfg_ok));

  mbist_ag_axis #(.W_MAX(XW_MAX)) u_xaxis (
    .clk(clk), .rst_n(rst_n), .width(cfg_use.xw), .down(cfg_use.down),
    .init(go), .step(x_step), .cnt(xcnt), .at_end(x_end));

  mbist_ag_axis #(.W_MAX(YW_MAX)) u_yaxis (
    .clk(clk), .rst_n(rst_n), .width(cfg_use.yw), .down(cfg_use.down),
    .init(go), .step(y_step), .cnt(ycnt), .at_end(y_end));

  mbist_ag_map #(.XW_MAX(XW_MAX), .YW_MAX(YW_MAX)) u_map (
    .xv(xcnt), .yv(ycnt), .xw(cfg_q.xw), .yw(cfg_q.yw), .cb(cfg_q.cb),
    .data(cfg_q.data), .addr(map_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_last  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (go) cfg_q <= cfg_in;
      if (go)                   busy <= 1'b1;
      else if (load && final_pt) busy <= 1'b0;
      if (load) begin
        out_valid <= 1'b1;
        out_addr  <= map_addr;
        out_last  <= final_pt;
      end else if (addr_ready) begin
        out_valid <= 1'b0;
      end
      done_q <= out_valid & addr_ready & out_last;
      if (rej)     err_q <= 1'b1;
      else if (go) err_q <= 1'b0;
    end
  end

  assign addr_valid = out_valid;
  assign addr       = out_addr;
  assign done       = done_q;
  assign cfg_err    = err_q;

  // R9: a stalled address is held
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr)));

  // R10: done only after a handshake, and the stream is then empty
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(addr_valid && addr_ready) && !addr_valid));

  // R1: an error flag means no run is in progress
  p_err_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R3: slow x moves only after fast y reached its end
  p_xslow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.fast_y && $past(busy) && !$stable(xcnt)) |-> $past(y_end));

  // R3: slow y moves only after fast x reached its end
  p_yslow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.fast_y && $past(busy) && !$stable(ycnt)) |-> $past(x_end));

  // R8: bits above the occupied span stay zero
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ((addr >> (2 + int'(cfg_q.xw) + int'(cfg_q.yw)
                     - (cfg_q.data ? 2 : 0))) == '0));
endmodule

// File: tb/sim_mbist_addr_gen.sv
`timescale 1ns/1ps
module sim_mbist_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, count_down = 1'b0, fast_y = 1'b0, data_ram = 1'b0;
  logic [3:0] col_bits = 4'd2, x_code = 4'd2, y_code = 4'd2;
  logic addr_valid, addr_ready = 1'b0, done, cfg_err;
  logic [19:0] addr;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mbist_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .count_down(count_down),
    .fast_y(fast_y), .data_ram(data_ram), .col_bits(col_bits),
    .x_code(x_code), .y_code(y_code), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .done(done), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(int x, int y, int xw, int yw,
                                           int c, bit data);
    logic [19:0] a = '0;
    int dv = data ? 2 : 0;
    if (data) begin a[0] = y[c]; a[1] = y[c+1]; end
    for (int j = 0; j < c; j++) a[2+j] = (j == 0) ? (y[0] ^ y[1]) : y[j];
    for (int j = 0; j < xw; j++) a[2+c+j] = x[j];
    for (int j = 0; j < yw - c - dv; j++) a[2+c+xw+j] = y[c+dv+j];
    return a;
  endfunction

  task automatic run_seq(input int xc, input int yc, input int cb,
                         input bit data, input bit dn, input bit fy,
                         input int rdy_pct, input bit poke);
    int total = 1 << (xc + yc);
    int fw = fy ? yc : xc;
    int sw = fy ? xc : yc;
    int k = 0;
    bit stall = 0, early = 0, hold_bad = 0, seq_bad = 0;
    logic [19:0] held, first_bad_act, first_bad_exp;
    x_code = 4'(xc); y_code = 4'(yc); col_bits = 4'(cb);
    data_ram = data; count_down = dn; fast_y = fy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b0, "R1", "err after good start", cfg_err, 0);
    while (k < total) begin
      if (done) early = 1;
      if (stall && !(addr_valid && addr == held)) hold_bad = 1;
      addr_ready = (int'($urandom % 100) < rdy_pct);
      if (addr_valid && addr_ready) begin
        int f = k & ((1 << fw) - 1);
        int s = k >> fw;
        int xv, yv;
        logic [19:0] e;
        if (dn) begin f = ((1 << fw) - 1) - f; s = ((1 << sw) - 1) - s; end
        xv = fy ? s : f;
        yv = fy ? f : s;
        e = exp_addr(xv, yv, xc, yc, cb, data);
        if (addr !== e && !seq_bad) begin
          seq_bad = 1; first_bad_act = addr; first_bad_exp = e;
        end
        k++;
      end
      stall = addr_valid && !addr_ready;
      held = addr;
      if (poke) start = (k == 2);
      if (poke && k == 2) x_code = 4'd0;
      if (poke && k == 3) x_code = 4'(xc);
      @(negedge clk);
    end
    start = 1'b0; x_code = 4'(xc);
    chk(!seq_bad, "R5", "address sequence (R3 R4 R6 R7 R8)", first_bad_act, first_bad_exp);
    chk(!hold_bad, "R9", "stalled address held", hold_bad, 0);
    chk(!early, "R10", "no early done", early, 0);
    chk(done == 1'b1 && addr_valid == 1'b0, "R10", "done after last", done, 1);
    addr_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done is one pulse", done, 0);
    if (poke) chk(cfg_err == 1'b0, "R10", "start ignored while active", cfg_err, 0);
  endtask

  task automatic bad_cfg(input int xc, input int yc, input int cb,
                         input bit data, input string req);
    bit seen = 0;
    x_code = 4'(xc); y_code = 4'(yc); col_bits = 4'(cb); data_ram = data;
    addr_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b1, req, "rejected start flags error", cfg_err, 1);
    for (int i = 0; i < 4; i++) begin
      if (addr_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, "no address after rejection", seen, 0);
    addr_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_valid == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R11",
        "reset state", {addr_valid, done, cfg_err}, 0);

    // directed corners
    bad_cfg(1, 4, 2, 0, "R1");
    bad_cfg(4, 11, 2, 0, "R1");
    bad_cfg(9, 4, 2, 0, "R1");
    bad_cfg(3, 4, 1, 0, "R2");
    bad_cfg(3, 5, 4, 1, "R2");
    run_seq(2, 2, 2, 0, 0, 0, 100, 0);      // R6 small, clears error
    run_seq(3, 4, 2, 1, 1, 1, 60, 0);       // R7 data, no block bits, down
    run_seq(2, 5, 5, 0, 0, 1, 50, 1);       // R10 poke, no block bits
    run_seq(3, 5, 2, 0, 1, 0, 40, 0);       // R4 down, fast x
    run_seq(8, 7, 4, 1, 0, 0, 100, 0);      // wide data layout

    // constrained random
    for (int r = 0; r < 16; r++) begin
      int xc = 2 + int'($urandom % 3);
      int yc = 2 + int'($urandom % 4);
      bit data = $urandom % 2;
      int cb;
      if (xc + yc > 8) yc = 8 - xc;
      if (yc < 4) data = 0;
      cb = 2 + int'($urandom % (yc - (data ? 2 : 0) - 1));
      run_seq(xc, yc, cb, data, 1'($urandom % 2), 1'($urandom % 2),
              30 + int'($urandom % 71), 1'($urandom % 2));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule